// File: doc/BRIEF.md
# Serial-Wire to JTAG Mode Switch Detector

This block watches the shared data/clock pins of a dual-protocol debug port while the port is in serial-wire mode. It samples the data line on each enabled clock edge and looks for a fixed entry sequence. The sequence is a long run of high bits that resets the line, then a 16-bit selection code sent least significant bit first, then a short run of high bits. When the whole sequence has been seen, the block commits the port to JTAG mode and raises a single-cycle change pulse.

Two selection codes are recognised: the current code 0xE73C and an older code 0xDEAE. Support for the older code can be removed with a parameter. A port built without JTAG support can use the same block with JTAG disabled, so that it stays in serial-wire mode. Each time a full reset run is completed, the block also gives a one-cycle line-reset indication that the serial-wire logic can use. The opposite switch, the packet engine and the TAP controller sit outside this block.

Top module: `swj_mode_detect`

## Requirements
- R1: After reset, `jtagMode`, `modeChangePulse` and `lineResetPulse` are all 0.
- R2: A saturating counter counts consecutive enabled samples with `dataBit`=1, up to RESET_RUN (50). Any enabled low sample clears it. `lineResetPulse` is high for exactly one cycle after the enabled sample that brings the count from RESET_RUN-1 to RESET_RUN. It does not pulse again until a low sample has restarted the run.
- R3: A cycle with `clkEn`=0 is not a sample. It changes no counter, no pattern progress and no output, so an enabled run that straddles disabled cycles still counts as one run.
- R4: Once the run counter is at RESET_RUN, the first enabled low sample is bit 0 of a 16-bit code, and the next 15 enabled samples are bits 1 to 15 (least significant bit first). If the code is 0xE73C and TRAIL_RUN (5) enabled high samples follow it, `jtagMode` becomes 1 right after the fifth of them, and `modeChangePulse` is high for that one cycle only.
- R5: With ACCEPT_ALT=1 (the default), the code 0xDEAE is accepted in the same way as 0xE73C.
- R6: A code that follows a run shorter than RESET_RUN high samples does not switch the mode.
- R7: A 16-bit code that matches neither accepted value sends the detector back to waiting for a new full run. A correct sequence sent afterwards still switches the mode.
- R8: A low sample among the TRAIL_RUN trailing samples aborts the switch, and `jtagMode` stays 0.
- R9: With JTAG_CAPABLE=0, `jtagMode` and `modeChangePulse` never become 1, whatever the input.
- R10: Once `jtagMode` is 1 it stays 1 until reset. Further input produces no further `modeChangePulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clkEn | input | 1 | High when `dataBit` holds a fresh sample from a rising debug-clock edge |
| dataBit | input | 1 | Sampled level of the shared data line |
| jtagMode | output | 1 | 1 once the port has been switched to JTAG mode |
| modeChangePulse | output | 1 | One-cycle pulse when `jtagMode` rises |
| lineResetPulse | output | 1 | One-cycle pulse when a full high run completes |

## Verification
The assertions assume that `rstN` is held low for at least one clock edge before any stimulus. They also assume that `dataBit` changes only while the clock is low, so that every enabled edge sees a stable sample. The bench drives each input on the falling edge and checks the outputs just after the following rising edge. The bench sweeps the length of the reset run on both sides of the threshold, every single-bit corruption of the selection code, and every position of a low bit in the trailing run. It runs each trial from reset and computes the expected outcome from the run length and the code value.

// File: rtl/swj_detect_pkg.sv
package swj_detect_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TRAIL = 2'd2,
    ST_JTAG  = 2'd3
  } detState_t;

  typedef struct packed {
    logic startPat;
    logic shiftEn;
    logic clrTrail;
    logic incTrail;
  } dpStrobes_t;

endpackage

// File: rtl/swj_detect_datapath.sv
module swj_detect_datapath
  import swj_detect_pkg::*;
#(
  parameter int unsigned RESET_RUN  = 50,
  parameter int unsigned TRAIL_RUN  = 5,
  parameter int unsigned PAT_W      = 16,
  parameter logic [15:0] MAIN_PAT   = 16'hE73C,
  parameter logic [15:0] ALT_PAT    = 16'hDEAE,
  parameter bit          ACCEPT_ALT = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkEn,
  input  logic       dataBit,
  input  dpStrobes_t strobe,
  output logic       runFull,
  output logic       lastBit,
  output logic       patHit,
  output logic       trailLast,
  output logic       lineResetPulse
);

  localparam int unsigned RUN_W = $clog2(RESET_RUN + 1);
  localparam int unsigned BIT_W = $clog2(PAT_W + 1);
  localparam int unsigned TR_W  = $clog2(TRAIL_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX   = RUN_W'(RESET_RUN);
  localparam logic [RUN_W-1:0] RUN_PRE   = RUN_W'(RESET_RUN - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(PAT_W - 1);
  localparam logic [TR_W-1:0]  TR_LAST   = TR_W'(TRAIL_RUN - 1);

  logic [RUN_W-1:0] highCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [TR_W-1:0]  trailCnt;
  logic [PAT_W-1:0] shReg;
  logic [PAT_W-1:0] nextShift;
  logic             mainHit;
  logic             altHit;

  // high-run counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highCnt        <= '0;
      lineResetPulse <= 1'b0;
    end else begin
      lineResetPulse <= 1'b0;
      if (clkEn) begin
        if (!dataBit) begin
          highCnt <= '0;
        end else if (highCnt != RUN_MAX) begin
          highCnt <= highCnt + 1'b1;
          if (highCnt == RUN_PRE) lineResetPulse <= 1'b1;
        end
      end
    end
  end

  assign runFull   = (highCnt == RUN_MAX);

  // LSB-first capture: new bit enters at the top
  assign nextShift = {dataBit, shReg[PAT_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      bitCnt <= '0;
    end else if (clkEn) begin
      if (strobe.startPat) begin
        shReg  <= nextShift;
        bitCnt <= BIT_W'(1);
      end else if (strobe.shiftEn) begin
        shReg  <= nextShift;
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign lastBit = (bitCnt == BIT_LAST);
  assign mainHit = (nextShift == MAIN_PAT[PAT_W-1:0]);

  generate
    if (ACCEPT_ALT) begin : g_alt
      assign altHit = (nextShift == ALT_PAT[PAT_W-1:0]);
    end else begin : g_noAlt
      assign altHit = 1'b0;
    end
  endgenerate

  assign patHit = mainHit | altHit;

  // trailing high-run counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trailCnt <= '0;
    end else if (clkEn) begin
      if (strobe.clrTrail)      trailCnt <= '0;
      else if (strobe.incTrail) trailCnt <= trailCnt + 1'b1;
    end
  end

  assign trailLast = (trailCnt == TR_LAST);

endmodule

// File: rtl/swj_detect_control.sv
module swj_detect_control
  import swj_detect_pkg::*;
#(
  parameter bit JTAG_CAPABLE = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkEn,
  input  logic       dataBit,
  input  logic       runFull,
  input  logic       lastBit,
  input  logic       patHit,
  input  logic       trailLast,
  output dpStrobes_t strobe,
  output logic       jtagMode,
  output logic       modeChangePulse
);

  detState_t state;
  detState_t stateNext;
  logic      commit;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    commit    = 1'b0;
    if (clkEn) begin
      unique case (state)
        ST_HUNT: begin
          if (!dataBit && runFull) begin
            strobe.startPat = 1'b1;
            stateNext       = ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          strobe.shiftEn = 1'b1;
          if (lastBit) begin
            if (patHit) begin
              strobe.clrTrail = 1'b1;
              stateNext       = ST_TRAIL;
            end else begin
              stateNext = ST_HUNT;
            end
          end
        end
        ST_TRAIL: begin
          if (!dataBit) begin
            stateNext = ST_HUNT;
          end else if (trailLast) begin
            if (JTAG_CAPABLE) begin
              commit    = 1'b1;
              stateNext = ST_JTAG;
            end else begin
              stateNext = ST_HUNT;
            end
          end else begin
            strobe.incTrail = 1'b1;
          end
        end
        ST_JTAG: stateNext = ST_JTAG;
        default: stateNext = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state           <= ST_HUNT;
      jtagMode        <= 1'b0;
      modeChangePulse <= 1'b0;
    end else begin
      state           <= stateNext;
      modeChangePulse <= commit;
      if (commit) jtagMode <= 1'b1;
    end
  end

endmodule

// File: rtl/swj_mode_detect.sv
module swj_mode_detect
  import swj_detect_pkg::*;
#(
  parameter int unsigned RESET_RUN    = 50,
  parameter int unsigned TRAIL_RUN    = 5,
  parameter int unsigned PAT_W        = 16,
  parameter logic [15:0] MAIN_PAT     = 16'hE73C,
  parameter logic [15:0] ALT_PAT      = 16'hDEAE,
  parameter bit          ACCEPT_ALT   = 1'b1,
  parameter bit          JTAG_CAPABLE = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic clkEn,
  input  logic dataBit,
  output logic jtagMode,
  output logic modeChangePulse,
  output logic lineResetPulse
);

  dpStrobes_t strobe;
  logic       runFull;
  logic       lastBit;
  logic       patHit;
  logic       trailLast;

  swj_detect_datapath #(
    .RESET_RUN (RESET_RUN),
    .TRAIL_RUN (TRAIL_RUN),
    .PAT_W     (PAT_W),
    .MAIN_PAT  (MAIN_PAT),
    .ALT_PAT   (ALT_PAT),
    .ACCEPT_ALT(ACCEPT_ALT)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .clkEn         (clkEn),
    .dataBit       (dataBit),
    .strobe        (strobe),
    .runFull       (runFull),
    .lastBit       (lastBit),
    .patHit        (patHit),
    .trailLast     (trailLast),
    .lineResetPulse(lineResetPulse)
  );

  swj_detect_control #(
    .JTAG_CAPABLE(JTAG_CAPABLE)
  ) u_ctl (
    .clk            (clk),
    .rstN           (rstN),
    .clkEn          (clkEn),
    .dataBit        (dataBit),
    .runFull        (runFull),
    .lastBit        (lastBit),
    .patHit         (patHit),
    .trailLast      (trailLast),
    .strobe         (strobe),
    .jtagMode       (jtagMode),
    .modeChangePulse(modeChangePulse)
  );

endmodule

// File: rtl/swj_mode_detect_chk.sv
module swj_mode_detect_chk #(
  parameter bit JTAG_CAPABLE = 1'b1
) (
  input logic clk,
  input logic rstN,
  input logic clkEn,
  input logic jtagMode,
  input logic modeChangePulse,
  input logic lineResetPulse
);

  // R10: mode is sticky once set
  a_r10_mode_sticky: assert property (@(posedge clk) disable iff (!rstN)
    jtagMode |=> jtagMode);

  // R4: change pulse coincides with the rise of the mode flag
  a_r4_pulse_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    modeChangePulse |-> (jtagMode && !$past(jtagMode)));

  a_r4_rise_has_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $rose(jtagMode) |-> modeChangePulse);

  // R2: line-reset indication lasts one cycle
  a_r2_line_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    lineResetPulse |=> !lineResetPulse);

  // R3: a disabled cycle moves nothing
  a_r3_hold_mode: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> $stable(jtagMode) && !lineResetPulse && !modeChangePulse);

  // R9: a port without JTAG never leaves serial-wire mode
  a_r9_no_jtag: assert property (@(posedge clk) disable iff (!rstN)
    !JTAG_CAPABLE |-> (!jtagMode && !modeChangePulse));

endmodule

bind swj_mode_detect swj_mode_detect_chk #(
  .JTAG_CAPABLE(JTAG_CAPABLE)
) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .clkEn          (clkEn),
  .jtagMode       (jtagMode),
  .modeChangePulse(modeChangePulse),
  .lineResetPulse (lineResetPulse)
);

// File: tb/swj_mode_detect_tb.sv
`timescale 1ns/100ps
module swj_mode_detect_tb;

  localparam int          RUN      = 50;
  localparam int          TRAIL    = 5;
  localparam logic [15:0] CODE_NEW = 16'hE73C;
  localparam logic [15:0] CODE_OLD = 16'hDEAE;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkEn = 1'b0;
  logic dataBit = 1'b0;
  logic jtagMode, modeChangePulse, lineResetPulse;
  logic njMode, njPulse, njLine;

  int nChecks = 0;
  int nFails = 0;
  int linePulses = 0;
  int modePulses = 0;
  int njSeen = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  swj_mode_detect u_dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .dataBit(dataBit),
    .jtagMode(jtagMode), .modeChangePulse(modeChangePulse),
    .lineResetPulse(lineResetPulse)
  );

  swj_mode_detect #(.JTAG_CAPABLE(1'b0)) u_dutNoJtag (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .dataBit(dataBit),
    .jtagMode(njMode), .modeChangePulse(njPulse),
    .lineResetPulse(njLine)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive on falling edge, sample just after the rising edge
  task automatic sendBit(input logic b, input logic en = 1'b1);
    @(negedge clk);
    dataBit = b;
    clkEn   = en;
    @(posedge clk);
    #1;
    if (lineResetPulse) linePulses++;
    if (modeChangePulse) modePulses++;
    if (njMode || njPulse) njSeen++;
  endtask

  task automatic sendRun(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b1);
  endtask

  task automatic sendCode(input logic [15:0] c);
    for (int i = 0; i < 16; i++) sendBit(c[i]);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; clkEn = 1'b0; dataBit = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    linePulses = 0; modePulses = 0;
    for (int i = 0; i < 3; i++) sendBit(1'b0);
  endtask

  // full trial; lowAt < 0 means clean trailing run
  task automatic trial(input int runLen, input logic [15:0] code, input int lowAt,
                       input string req);
    bit expSwitch;
    doReset();
    sendRun(runLen);
    check(linePulses == ((runLen >= RUN) ? 1 : 0), "R2", linePulses,
          (runLen >= RUN) ? 1 : 0);
    sendCode(code);
    expSwitch = (runLen >= RUN) && ((code == CODE_NEW) || (code == CODE_OLD)) && (lowAt < 0);
    for (int i = 0; i < TRAIL; i++) begin
      sendBit((i == lowAt) ? 1'b0 : 1'b1);
      if (i == TRAIL - 2) check(jtagMode == 1'b0, "R4 early", jtagMode, 0);
    end
    check(jtagMode == expSwitch, req, jtagMode, expSwitch);
    check(modeChangePulse == expSwitch, req, modeChangePulse, expSwitch);
    sendBit(1'b1);
    check(modeChangePulse == 1'b0, "R4 pulse width", modeChangePulse, 0);
    check(modePulses == (expSwitch ? 1 : 0), req, modePulses, expSwitch ? 1 : 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #1;
    check(jtagMode == 0 && modeChangePulse == 0 && lineResetPulse == 0, "R1",
          {jtagMode, modeChangePulse, lineResetPulse}, 0);
    doReset();
    check(jtagMode == 0 && modeChangePulse == 0 && lineResetPulse == 0, "R1 after rise",
          {jtagMode, modeChangePulse, lineResetPulse}, 0);

    // R2 saturating run, one pulse, right after the 50th high
    sendRun(RUN - 1);
    check(linePulses == 0, "R2 before", linePulses, 0);
    sendBit(1'b1);
    check(lineResetPulse == 1'b1, "R2 at 50", lineResetPulse, 1);
    sendRun(70);
    check(linePulses == 1, "R2 saturate", linePulses, 1);
    sendBit(1'b0);
    sendRun(RUN);
    check(linePulses == 2, "R2 rerun", linePulses, 2);

    // R4/R6 run-length sweep with the new code
    for (int r = RUN - 5; r <= RUN + 5; r++) trial(r, CODE_NEW, -1, "R4/R6 run sweep");
    // R5 old code
    trial(RUN, CODE_OLD, -1, "R5 old code");
    trial(RUN + 3, CODE_OLD, -1, "R5 old code long run");
    // R7 every single-bit corruption of each code
    for (int b = 0; b < 16; b++) begin
      trial(RUN, CODE_NEW ^ (16'h1 << b), -1, "R7 corrupt new");
      trial(RUN, CODE_OLD ^ (16'h1 << b), -1, "R7 corrupt old");
    end
    // R7 recovery after a bad code
    doReset();
    sendRun(RUN); sendCode(16'h1234);
    sendRun(RUN); sendCode(CODE_NEW); sendRun(TRAIL);
    check(jtagMode == 1'b1, "R7 recover", jtagMode, 1);
    // R8 low in every trailing position
    for (int p = 0; p < TRAIL; p++) trial(RUN, CODE_NEW, p, "R8 trail low");

    // R3 disabled cycles inside the run and code
    doReset();
    sendRun(30);
    for (int i = 0; i < 5; i++) sendBit(1'b0, 1'b0);
    sendRun(RUN - 30);
    check(linePulses == 1, "R3 run straddles", linePulses, 1);
    sendCode(CODE_NEW);
    sendBit(1'b1); sendBit(1'b0, 1'b0); sendRun(TRAIL - 2);
    check(jtagMode == 1'b0, "R3 gap not sample", jtagMode, 0);
    sendBit(1'b1);
    check(jtagMode == 1'b1, "R3 switch", jtagMode, 1);

    // R10 sticky, no more pulses
    modePulses = 0;
    sendRun(RUN + 10); sendCode(CODE_OLD); sendRun(TRAIL); sendBit(1'b0);
    check(jtagMode == 1'b1, "R10 sticky", jtagMode, 1);
    check(modePulses == 0, "R10 no pulse", modePulses, 0);

    // R9 no-JTAG instance saw every sequence above
    check(njSeen == 0, "R9 no jtag", njSeen, 0);
    check(njMode == 1'b0, "R9 mode", njMode, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule